// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a page directory whose base comes from a root input, and then, for ordinary 4 KiB pages, a page table. Each table holds 1024 four-byte entries and fills exactly one 4 KiB page, so the two levels together span the whole 4 GiB linear space. The walker accepts one request at a time through a valid/ready handshake and fetches entries one word at a time on a simple memory port. A write has no response. A read returns one response word later. The walker reports either a physical address or a fault with a three-bit error code.

When the global large-page enable is high and the directory entry has its size flag set, the walk stops at the directory and maps a 4 MiB page. When the enable is low, the size flag has no effect. After a walk that succeeds, the walker writes back every entry it read whose accessed flag was clear, with that flag set, before it reports the result.

Top module: `pgwalk`

## Requirements
- R1: `req_ready` is high only while the walker is idle, including the first cycle after reset. A request is taken when `req_valid` and `req_ready` are both high, and `req_ready` then stays low until the walk finishes. Each result appears as a single-cycle `rsp_valid` pulse.
- R2: The first read of a walk goes to address {`root_base`[31:12], va[31:22], 2'b00}. The low 12 bits of `root_base` are ignored.
- R3: On a two-level walk, the second read goes to address {dir[31:12], va[21:12], 2'b00}, where dir is the directory entry just read.
- R4: A two-level walk that succeeds returns `rsp_fault`=0 and `rsp_pa` = {pte[31:12], va[11:0]}.
- R5: When `large_en`=1 and directory bit 7 is set, the walker reads exactly one entry. It returns `rsp_pa` = {dir[31:22], va[21:0]}.
- R6: When `large_en`=0, directory bit 7 is ignored and the walker does a normal two-level walk.
- R7: If bit 0 (present) of the entry at either level is clear, the walk ends at once with `rsp_fault`=1 and `rsp_pa`=0. The error code is bit0=0, bit1=write access, bit2=user access. No write-back is done.
- R8: A write access to an entry with bit 1 clear, or a user access to an entry with bit 2 clear, at either level, faults with error code bit0=1, bit1=write access and bit2=user access. No write-back is done.
- R9: On success, each entry read whose bit 5 (accessed) was clear is written back to its own address, with its original contents OR 0x20. The directory entry is written before the table entry, and all write-backs happen before `rsp_valid`. Entries with bit 5 already set are not written.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays asserted with address, write flag and write data held stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user level |
| root_base | input | 32 | Directory base; bits 11:0 ignored |
| large_en | input | 1 | Allows 4 MiB pages at the directory level |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_req_we | output | 1 | 1 = write-back, 0 = read |
| mem_req_wdata | output | 32 | Write-back data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | Result pulse |
| rsp_pa | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_err | output | 3 | {user, write, present-or-protection} |

## Verification
The bench sweeps every combination of the present, write, user, accessed and size flags in the directory entry and of the four flags in the table entry. Each combination is tried with write access, user access and the large-page enable both on and off. Across this sweep the virtual address, the root and the table bases change together, so a wrong index, offset or frame bit shows up as a wrong address rather than as a coincidental match. Each case tells apart four outcomes: a not-present fault, a protection fault, a large-page hit, and an ordinary two-level translation. The memory model stalls requests and varies its read latency, which exercises the hold rule and the ordering of write-backs.

// File: rtl/pgwalk_pkg.sv
`timescale 1ns/1ps
package pgwalk_pkg;

   // entry flag positions
   localparam int FLG_PRESENT = 0;
   localparam int FLG_WRITE   = 1;
   localparam int FLG_USER    = 2;
   localparam int FLG_ACCESS  = 5;
   localparam int FLG_BIG     = 7;

   typedef enum logic [2:0] {
      WS_IDLE,
      WS_DIR_REQ,
      WS_DIR_WAIT,
      WS_TBL_REQ,
      WS_TBL_WAIT,
      WS_DIR_WB,
      WS_TBL_WB,
      WS_DONE
   } walk_state_t;

endpackage

// File: rtl/pgwalk_slot.sv
`timescale 1ns/1ps
// Forms the byte address of one table slot from a page-aligned base and an index.
module pgwalk_slot #(
   parameter int AW    = 32,
   parameter int IDX_W = 10,
   parameter int OFF_W = 12
) (
   input  logic [AW-OFF_W-1:0] base_hi,
   input  logic [IDX_W-1:0]    idx,
   output logic [AW-1:0]       addr
);
   localparam int ESZ_LOG2 = OFF_W - IDX_W;

   assign addr = {base_hi, idx, {ESZ_LOG2{1'b0}}};
endmodule

// File: rtl/pgwalk_perm.sv
`timescale 1ns/1ps
// Decides whether an entry allows the access and builds the error code.
module pgwalk_perm (
   input  logic       present,
   input  logic       can_write,
   input  logic       can_user,
   input  logic       is_write,
   input  logic       is_user,
   output logic       fault,
   output logic [2:0] err
);
   logic denied;

   assign denied = (is_write & ~can_write) | (is_user & ~can_user);
   assign fault  = ~present | denied;
   assign err    = {is_user, is_write, present};
endmodule

// File: rtl/pgwalk.sv
`timescale 1ns/1ps
module pgwalk
   import pgwalk_pkg::*;
#(
   parameter int VA_W        = 32,
   parameter int IDX_W       = 10,
   parameter int OFF_W       = 12,
   parameter bit LARGE_PAGES = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_va,
   input  logic             req_write,
   input  logic             req_user,
   input  logic [VA_W-1:0]  root_base,
   input  logic             large_en,
   output logic             mem_req_valid,
   input  logic             mem_req_ready,
   output logic [VA_W-1:0]  mem_req_addr,
   output logic             mem_req_we,
   output logic [VA_W-1:0]  mem_req_wdata,
   input  logic             mem_rsp_valid,
   input  logic [VA_W-1:0]  mem_rsp_rdata,
   output logic             rsp_valid,
   output logic [VA_W-1:0]  rsp_pa,
   output logic             rsp_fault,
   output logic [2:0]       rsp_err
);
   localparam int HI_W   = VA_W - OFF_W;
   localparam int LOFF_W = IDX_W + OFF_W;
   localparam int BIG_W  = VA_W - LOFF_W;
   localparam logic [VA_W-1:0] ACC_MASK = VA_W'(1) << FLG_ACCESS;

   // elaboration-time configuration checks
   if (VA_W != 2*IDX_W + OFF_W) begin : g_bad_split
      $error("pgwalk: VA_W must equal 2*IDX_W + OFF_W");
   end
   if (OFF_W != IDX_W + 2) begin : g_bad_entry
      $error("pgwalk: a table of 4-byte entries must fill one page");
   end
   if (OFF_W <= FLG_BIG) begin : g_bad_flags
      $error("pgwalk: flag bits must sit below the page offset width");
   end

   walk_state_t       st;
   logic [VA_W-1:0]   va_q;
   logic              wr_q, usr_q, lg_q;
   logic [HI_W-1:0]   root_q;
   logic [VA_W-1:0]   de_q, te_q;
   logic              big_q, fault_q;
   logic [2:0]        err_q;

   logic              root_lo_unused;
   assign root_lo_unused = ^root_base[OFF_W-1:0];

   // ---------------- slot addresses ----------------
   logic [VA_W-1:0] dir_addr, tbl_addr;

   pgwalk_slot #(.AW(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_dir_slot (
      .base_hi (root_q),
      .idx     (va_q[VA_W-1 -: IDX_W]),
      .addr    (dir_addr)
   );

   pgwalk_slot #(.AW(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_tbl_slot (
      .base_hi (de_q[VA_W-1 -: HI_W]),
      .idx     (va_q[LOFF_W-1 -: IDX_W]),
      .addr    (tbl_addr)
   );

   // ---------------- entry checks ----------------
   logic       chk_fault;
   logic [2:0] chk_err;

   pgwalk_perm u_perm (
      .present   (mem_rsp_rdata[FLG_PRESENT]),
      .can_write (mem_rsp_rdata[FLG_WRITE]),
      .can_user  (mem_rsp_rdata[FLG_USER]),
      .is_write  (wr_q),
      .is_user   (usr_q),
      .fault     (chk_fault),
      .err       (chk_err)
   );

   logic dir_is_big;
   if (LARGE_PAGES) begin : g_big
      assign dir_is_big = lg_q & mem_rsp_rdata[FLG_BIG];
   end else begin : g_flat
      logic lg_unused;
      assign lg_unused  = lg_q;
      assign dir_is_big = 1'b0;
   end

   // ---------------- walk sequencer ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= WS_IDLE;
         va_q    <= '0;
         wr_q    <= 1'b0;
         usr_q   <= 1'b0;
         lg_q    <= 1'b0;
         root_q  <= '0;
         de_q    <= '0;
         te_q    <= '0;
         big_q   <= 1'b0;
         fault_q <= 1'b0;
         err_q   <= '0;
      end else begin
         unique case (st)
            WS_IDLE: if (req_valid) begin
               va_q    <= req_va;
               wr_q    <= req_write;
               usr_q   <= req_user;
               lg_q    <= large_en;
               root_q  <= root_base[VA_W-1:OFF_W];
               big_q   <= 1'b0;
               fault_q <= 1'b0;
               err_q   <= '0;
               st      <= WS_DIR_REQ;
            end
            WS_DIR_REQ: if (mem_req_ready) st <= WS_DIR_WAIT;
            WS_DIR_WAIT: if (mem_rsp_valid) begin
               de_q <= mem_rsp_rdata;
               if (chk_fault) begin
                  fault_q <= 1'b1;
                  err_q   <= chk_err;
                  st      <= WS_DONE;
               end else if (dir_is_big) begin
                  big_q <= 1'b1;
                  st    <= mem_rsp_rdata[FLG_ACCESS] ? WS_DONE : WS_DIR_WB;
               end else begin
                  st <= WS_TBL_REQ;
               end
            end
            WS_TBL_REQ: if (mem_req_ready) st <= WS_TBL_WAIT;
            WS_TBL_WAIT: if (mem_rsp_valid) begin
               te_q <= mem_rsp_rdata;
               if (chk_fault) begin
                  fault_q <= 1'b1;
                  err_q   <= chk_err;
                  st      <= WS_DONE;
               end else if (!de_q[FLG_ACCESS]) begin
                  st <= WS_DIR_WB;
               end else if (!mem_rsp_rdata[FLG_ACCESS]) begin
                  st <= WS_TBL_WB;
               end else begin
                  st <= WS_DONE;
               end
            end
            WS_DIR_WB: if (mem_req_ready) begin
               if (big_q || te_q[FLG_ACCESS]) st <= WS_DONE;
               else                           st <= WS_TBL_WB;
            end
            WS_TBL_WB: if (mem_req_ready) st <= WS_DONE;
            WS_DONE:   st <= WS_IDLE;
            default:   st <= WS_IDLE;
         endcase
      end
   end

   // ---------------- outputs ----------------
   logic on_dir;
   assign on_dir = (st == WS_DIR_REQ) || (st == WS_DIR_WB);

   assign req_ready     = (st == WS_IDLE);
   assign mem_req_valid = (st == WS_DIR_REQ) || (st == WS_TBL_REQ) ||
                          (st == WS_DIR_WB)  || (st == WS_TBL_WB);
   assign mem_req_we    = (st == WS_DIR_WB) || (st == WS_TBL_WB);
   assign mem_req_addr  = on_dir ? dir_addr : tbl_addr;
   assign mem_req_wdata = (on_dir ? de_q : te_q) | ACC_MASK;

   assign rsp_valid = (st == WS_DONE);
   assign rsp_fault = fault_q;
   assign rsp_err   = err_q;

   always_comb begin
      if (fault_q)    rsp_pa = '0;
      else if (big_q) rsp_pa = {de_q[VA_W-1 -: BIG_W], va_q[LOFF_W-1:0]};
      else            rsp_pa = {te_q[VA_W-1 -: HI_W], va_q[OFF_W-1:0]};
   end

   // ---------------- assertions ----------------
   p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
                                          $stable(mem_req_we) && $stable(mem_req_wdata));

   p_busy_after_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready && !rsp_valid);

   p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid && req_ready);

   p_offset_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_fault |-> rsp_pa[OFF_W-1:0] == va_q[OFF_W-1:0]);

   p_wb_sets_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_we |-> mem_req_wdata[FLG_ACCESS]);

   p_fault_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault |-> rsp_err[1] == wr_q && rsp_err[2] == usr_q && rsp_pa == '0);

   p_no_wb_after_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fault_q |-> !mem_req_valid);
endmodule

// File: tb/test_pgwalk.sv
`timescale 1ns/1ps
module test_pgwalk;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_va = '0;
   logic        req_write = 1'b0;
   logic        req_user = 1'b0;
   logic [31:0] root_base = '0;
   logic        large_en = 1'b0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr;
   logic        mem_req_we;
   logic [31:0] mem_req_wdata;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_rdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_pa;
   logic        rsp_fault;
   logic [2:0]  rsp_err;

   always #4 clk = ~clk;   // 125 MHz

   pgwalk i_pgwalk (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
      .req_write(req_write), .req_user(req_user), .root_base(root_base),
      .large_en(large_en),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_req_we(mem_req_we),
      .mem_req_wdata(mem_req_wdata),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
      .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
      .rsp_err(rsp_err)
   );

   int n_checks = 0;
   int n_fail   = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- memory model ----------------
   logic [31:0] mem [4096];
   logic [31:0] rd_log [4];
   logic [31:0] wa_log [4];
   logic [31:0] wd_log [4];
   int          rd_n = 0;
   int          wr_n = 0;
   int          rsp_cd = 0;
   int          stall_ctr = 0;
   logic [31:0] rsp_hold = '0;
   bit          hold_pend = 1'b0;
   logic [31:0] hold_addr = '0;
   logic [31:0] hold_wd = '0;
   logic        hold_we = 1'b0;

   always @(negedge clk) begin
      if (!rst_n) begin
         mem_req_ready = 1'b0;
         mem_rsp_valid = 1'b0;
         rsp_cd        = 0;
         hold_pend     = 1'b0;
      end else begin
         mem_rsp_valid = 1'b0;
         if (rsp_cd != 0) begin
            rsp_cd--;
            if (rsp_cd == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_rdata = rsp_hold;
            end
         end
         if (hold_pend)
            chk(mem_req_valid && mem_req_addr == hold_addr && mem_req_we == hold_we &&
                mem_req_wdata == hold_wd, "R10 stalled request held",
                {mem_req_valid, mem_req_we, mem_req_addr}, {1'b1, hold_we, hold_addr});
         hold_pend     = 1'b0;
         mem_req_ready = 1'b0;
         if (mem_req_valid && rsp_cd == 0 && !mem_rsp_valid) begin
            stall_ctr++;
            if (stall_ctr % 3 == 2) begin
               hold_pend = 1'b1;
               hold_addr = mem_req_addr;
               hold_we   = mem_req_we;
               hold_wd   = mem_req_wdata;
            end else begin
               mem_req_ready = 1'b1;
               if (mem_req_we) begin
                  mem[mem_req_addr[13:2]] = mem_req_wdata;
                  if (wr_n < 4) begin
                     wa_log[wr_n] = mem_req_addr;
                     wd_log[wr_n] = mem_req_wdata;
                  end
                  wr_n++;
               end else begin
                  if (rd_n < 4) rd_log[rd_n] = mem_req_addr;
                  rd_n++;
                  rsp_hold = mem[mem_req_addr[13:2]];
                  rsp_cd   = 1 + (stall_ctr % 2);
               end
            end
         end
      end
   end

   // ---------------- one translation ----------------
   task automatic run_case(input int k);
      logic [11:0] kb;
      logic [31:0] root, va, d, t, dir_a, tbl_a, ex_pa;
      logic        wr, usr, lg, ex_fault, big;
      logic [2:0]  ex_err;
      int          ex_rd, ex_wn, n;
      logic [31:0] ex_wa [2];
      logic [31:0] ex_wd [2];
      string       tag;

      kb   = 12'(k);
      wr   = kb[9];
      usr  = kb[10];
      lg   = kb[11];
      root = {12'(k*5+1), 8'h01, 12'hABC};
      va   = {10'(k*7+3), 10'(k*13), 12'(k*97)};
      d    = {10'(k*11+1), 8'(k), 1'b1, kb[6], 4'(k*3), kb[4], 1'b0, kb[3], 2'b00,
              kb[2], kb[1], kb[0]};
      t    = {20'(k*40503+7), 6'(k), kb[8], 2'b00, kb[7], kb[6], kb[5]};
      dir_a = {root[31:12], va[31:22], 2'b00};
      tbl_a = {d[31:12], va[21:12], 2'b00};
      mem[dir_a[13:2]] = d;
      mem[tbl_a[13:2]] = t;

      // expected outcome from the requirements
      ex_fault = 1'b0; ex_err = 3'b000; ex_pa = '0; ex_rd = 1; ex_wn = 0;
      ex_wa[0] = '0; ex_wa[1] = '0; ex_wd[0] = '0; ex_wd[1] = '0;
      big = lg && d[7];
      if (!d[0]) begin
         ex_fault = 1'b1; ex_err = {usr, wr, 1'b0}; tag = "R7 dir not present";
      end else if ((wr && !d[1]) || (usr && !d[2])) begin
         ex_fault = 1'b1; ex_err = {usr, wr, 1'b1}; tag = "R8 dir protection";
      end else if (big) begin
         ex_pa = {d[31:22], va[21:0]}; tag = "R5 large page";
         if (!d[5]) begin ex_wn = 1; ex_wa[0] = dir_a; ex_wd[0] = d | 32'h20; end
      end else begin
         ex_rd = 2;
         if (!t[0]) begin
            ex_fault = 1'b1; ex_err = {usr, wr, 1'b0}; tag = "R7 table not present";
         end else if ((wr && !t[1]) || (usr && !t[2])) begin
            ex_fault = 1'b1; ex_err = {usr, wr, 1'b1}; tag = "R8 table protection";
         end else begin
            ex_pa = {t[31:12], va[11:0]};
            tag = d[7] ? "R6 size flag ignored" : "R4 small page";
            if (!d[5]) begin
               ex_wa[ex_wn] = dir_a; ex_wd[ex_wn] = d | 32'h20; ex_wn++;
            end
            if (!t[5]) begin
               ex_wa[ex_wn] = tbl_a; ex_wd[ex_wn] = t | 32'h20; ex_wn++;
            end
         end
      end

      rd_n = 0;
      wr_n = 0;
      @(negedge clk);
      req_va = va; req_write = wr; req_user = usr; root_base = root; large_en = lg;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R1 busy during walk", 64'(req_ready), 64'd0);
      n = 0;
      while (!rsp_valid && n < 200) begin
         @(negedge clk);
         n++;
      end
      if (n >= 200) begin
         chk(1'b0, "R1 walk timeout", 64'(n), 64'd0);
      end else begin
         chk(rsp_fault == ex_fault && rsp_err == ex_err && rsp_pa == ex_pa, tag,
             {28'd0, rsp_fault, rsp_err, rsp_pa}, {28'd0, ex_fault, ex_err, ex_pa});
         chk(rd_n == ex_rd, "R5 read count", 64'(rd_n), 64'(ex_rd));
         chk(rd_log[0] == dir_a, "R2 directory slot address", 64'(rd_log[0]), 64'(dir_a));
         if (ex_rd == 2 && rd_n >= 2)
            chk(rd_log[1] == tbl_a, "R3 table slot address", 64'(rd_log[1]), 64'(tbl_a));
         chk(wr_n == ex_wn, "R9 write-back count", 64'(wr_n), 64'(ex_wn));
         for (int i = 0; i < ex_wn && i < wr_n; i++)
            chk(wa_log[i] == ex_wa[i] && wd_log[i] == ex_wd[i], "R9 write-back content",
                {wa_log[i], wd_log[i]}, {ex_wa[i], ex_wd[i]});
         @(negedge clk);
         chk(!rsp_valid && req_ready, "R1 single result pulse",
             {62'd0, rsp_valid, req_ready}, 64'd1);
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(8 * 190000);
      n_fail++;
      n_checks++;
      $display("FAIL R1 watchdog expired: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   // ---------------- main sequence ----------------
   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !rsp_valid && !mem_req_valid, "R1 reset state",
          {61'd0, req_ready, rsp_valid, mem_req_valid}, 64'b100);
      for (int k = 0; k < 4096; k++) run_case(k);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule